// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Coherent Two-Byte Read

This block is a 16-bit up-counter that a byte-wide bus reads. The bus clock drives a fixed divide-by-four prescaler, and the counter advances by one each time the prescaler wraps. After reset the counter holds 0xFFFC. It does not move until the start enable goes high. That input stands in for the oscillator start-up delay.

Software reads the count as two bytes. A read of the high byte stores the low byte of the same instant in a small buffer. The next low-byte read returns that stored byte, so the pair always forms one sample while the counter keeps running. An overflow flag is set when the count rolls over. It stays set until a clear strobe arrives.

Read data is combinational. The byte appears on `rd_data` in the same cycle as the read strobe. The buffer and the pending state update on the following clock edge.

Top module: `frt_coherent_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter loads 0xFFFC, the overflow flag clears, the prescaler phase goes to zero and no high-byte read is pending. A read straight after reset returns 0xFF for the high byte and 0xFC for the low byte.
- R2: While `start_en` is low, neither the counter nor the prescaler phase changes.
- R3: While `start_en` is high, the counter increments by exactly one on every fourth clock, and on no other clock.
- R4: In a cycle with `rd_hi` high, `rd_data` shows the counter's high byte (bits 15:8). If no read is pending, the counter's low byte (bits 7:0) in that same cycle is stored and a read becomes pending.
- R5: In a cycle with `rd_lo` high, `rd_hi` low and a read pending, `rd_data` shows the stored byte and the pending state ends.
- R6: Further `rd_hi` strobes while a read is pending leave the stored byte unchanged.
- R7: In a cycle with `rd_lo` high, `rd_hi` low and no read pending, `rd_data` shows the counter's live low byte.
- R8: Read strobes, in any order and any number, change neither the counter nor the overflow flag.
- R9: When the counter steps from 0xFFFF to 0x0000, `ovf_flag` is high from the next cycle on.
- R10: `ovf_flag` stays high until a cycle with `ovf_clr` high. If a rollover and `ovf_clr` fall in the same cycle, the rollover wins and the flag is set.
- R11: If `rd_hi` and `rd_lo` are high in the same cycle, the high-byte read takes effect and the low-byte strobe is ignored. In a cycle with neither strobe, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start_en | input | 1 | Allows the prescaler and counter to run |
| rd_hi | input | 1 | High-byte read strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_data | output | 8 | Byte returned for the current read strobe |
| ovf_flag | output | 1 | Overflow flag, set on rollover |

## Verification
Two pairs of events can land in the same cycle. The first is a counter rollover together with an overflow clear. The bench provokes it by holding `ovf_clr` high through the prescaled step from 0xFFFF to 0x0000. It then expects the flag to be high in the next cycle and low one cycle after that. The second is a high-byte read together with a low-byte read in one cycle. The random phase produces this often. A bench reference model, written from the requirements, judges each case by the byte returned and by the low-byte reads that follow.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int unsigned CNT_W   = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PRE_DIV = 4;
    localparam logic [CNT_W-1:0] CNT_RST = 16'hFFFC;

    // Source of the byte placed on the read bus.
    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_HIGH,
        SRC_SNAP,
        SRC_LIVE
    } rd_src_e;

    // Low-byte snapshot and its pending marker.
    typedef struct packed {
        logic              pending;
        logic [BYTE_W-1:0] lo_byte;
    } snap_t;

    function automatic logic [BYTE_W-1:0] upper_byte(input logic [CNT_W-1:0] v);
        return v[CNT_W-1 -: BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lower_byte(input logic [CNT_W-1:0] v);
        return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
    parameter int unsigned DIV = frt_pkg::PRE_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (run) begin
            if (phase_q == LAST) phase_q <= '0;
            else                 phase_q <= phase_q + PW'(1);
        end
    end
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int unsigned           W       = frt_pkg::CNT_W,
    parameter logic [W-1:0]          RST_VAL = frt_pkg::CNT_RST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic         flag
);
    logic wrap;

    assign wrap = step && (&count);

    always_ff @(posedge clk) begin
        if (rst)       count <= RST_VAL;
        else if (step) count <= count + W'(1);
    end

    // A rollover takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/frt_read_seq.sv
module frt_read_seq
    import frt_pkg::*;
#(
    parameter int unsigned W  = CNT_W,
    parameter int unsigned BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_hi,
    input  logic          rd_lo,
    input  logic [W-1:0]  live,
    output logic [BW-1:0] rd_data,
    output snap_t         snap
);
    rd_src_e src;

    always_comb begin
        if (rd_hi)                     src = SRC_HIGH;
        else if (rd_lo && snap.pending) src = SRC_SNAP;
        else if (rd_lo)                src = SRC_LIVE;
        else                           src = SRC_IDLE;
    end

    always_comb begin
        unique case (src)
            SRC_HIGH: rd_data = upper_byte(live);
            SRC_SNAP: rd_data = snap.lo_byte;
            SRC_LIVE: rd_data = lower_byte(live);
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (rd_hi && !snap.pending) begin
            snap.pending <= 1'b1;
            snap.lo_byte <= lower_byte(live);
        end else if (rd_lo && !rd_hi) begin
            snap.pending <= 1'b0;
        end
    end
endmodule

// File: rtl/frt_coherent_timer.sv
module frt_coherent_timer
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_en,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_flag
);
    logic             pre_tick;
    logic [CNT_W-1:0] cnt_q;
    snap_t            rs_snap;

    frt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (start_en),
        .tick (pre_tick)
    );

    frt_counter #(.W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (pre_tick),
        .flag_clr (ovf_clr),
        .count    (cnt_q),
        .flag     (ovf_flag)
    );

    frt_read_seq #(.W(CNT_W), .BW(BYTE_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo),
        .live    (cnt_q),
        .rd_data (rd_data),
        .snap    (rs_snap)
    );
endmodule

// File: rtl/frt_checker.sv
module frt_checker
    import frt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_en,
    input logic              rd_hi,
    input logic              rd_lo,
    input logic              ovf_clr,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf,
    input snap_t             snap,
    input logic [BYTE_W-1:0] rd_data
);
    a_r1_reset_flag: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ovf && !snap.pending && cnt == CNT_RST));

    a_r2_stall: assert property (@(posedge clk) disable iff (rst)
        !start_en |=> $stable(cnt));

    a_r3_no_step: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    a_r4_high_byte: assert property (@(posedge clk) disable iff (rst)
        rd_hi |-> rd_data == cnt[CNT_W-1 -: BYTE_W]);

    a_r5_snap_out: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !rd_hi && snap.pending) |-> rd_data == snap.lo_byte);

    a_r6_hold_snap: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && snap.pending) |=> ($stable(snap.lo_byte) && snap.pending));

    a_r9_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (tick && (&cnt)) |=> ovf);

    a_r10_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind frt_coherent_timer frt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_en (start_en),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .ovf_clr  (ovf_clr),
    .tick     (pre_tick),
    .cnt      (cnt_q),
    .ovf      (ovf_flag),
    .snap     (rs_snap),
    .rd_data  (rd_data)
);

// File: tb/sim_frt_coherent_timer.sv
`timescale 1ns/1ps
module sim_frt_coherent_timer;
    logic       clk = 1'b0;
    logic       rst, start_en, rd_hi, rd_lo, ovf_clr;
    logic [7:0] rd_data;
    logic       ovf_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference state, written from the requirements.
    logic [1:0]  m_ph;
    logic [15:0] m_cnt;
    logic        m_ovf, m_pend;
    logic [7:0]  m_buf;

    always #5 clk = ~clk;

    frt_coherent_timer u0 (
        .clk(clk), .rst(rst), .start_en(start_en), .rd_hi(rd_hi),
        .rd_lo(rd_lo), .ovf_clr(ovf_clr), .rd_data(rd_data), .ovf_flag(ovf_flag)
    );

    function automatic logic [7:0] exp_data(input logic hi, input logic lo);
        if (hi)          return m_cnt[15:8];
        if (lo && m_pend) return m_buf;
        if (lo)          return m_cnt[7:0];
        return 8'h00;
    endfunction

    function automatic string data_tag(input logic hi, input logic lo);
        if (hi && lo) return "R11";
        if (hi)       return m_pend ? "R6" : "R4";
        if (lo)       return m_pend ? "R5" : "R7";
        return "R11";
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp, input string ctx);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s): actual=%h expected=%h", tag, ctx, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 2'd0; m_cnt = 16'hFFFC; m_ovf = 1'b0; m_pend = 1'b0; m_buf = 8'h00;
    endtask

    // One bus cycle: drive after the falling edge, check, then advance the model.
    task automatic step(input logic hi, input logic lo, input logic clr,
                        input logic en, input string ctx);
        logic tk;
        @(negedge clk);
        rd_hi = hi; rd_lo = lo; ovf_clr = clr; start_en = en;
        #1;
        check8(data_tag(hi, lo), rd_data, exp_data(hi, lo), ctx);
        check8("R9 R10", {7'd0, ovf_flag}, {7'd0, m_ovf}, ctx);
        @(posedge clk);
        tk = en && (m_ph == 2'd3);
        if (en) m_ph = m_ph + 2'd1;
        if (hi && !m_pend) begin
            m_pend = 1'b1; m_buf = m_cnt[7:0];
        end else if (lo && !hi) begin
            m_pend = 1'b0;
        end
        if (tk && m_cnt == 16'hFFFF) m_ovf = 1'b1;
        else if (clr)               m_ovf = 1'b0;
        if (tk) m_cnt = m_cnt + 16'd1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_en = 0; rd_hi = 0; rd_lo = 0; ovf_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1'b1; start_en = 0; rd_hi = 0; rd_lo = 0; ovf_clr = 0;
        do_reset();

        // R1: reset value read back as a coherent pair
        check8("R1", {7'd0, ovf_flag}, 8'h00, "flag after reset");
        step(1, 0, 0, 0, "R1 high byte after reset");
        step(0, 1, 0, 0, "R1 low byte after reset");

        // R2: counter frozen with start_en low
        repeat (40) step(0, 0, 0, 0, "R2 idle");
        step(1, 0, 0, 0, "R2 high");
        step(0, 1, 0, 0, "R2 low");

        // R3/R8: run, with reads in many orders, pair still coherent
        repeat (7) step(0, 0, 0, 1, "R3 run");
        step(1, 0, 0, 1, "R4 capture");
        repeat (9) step(1, 0, 0, 1, "R6 repeat high");
        step(0, 1, 0, 1, "R5 buffered low");
        step(0, 1, 0, 1, "R7 live low");
        step(0, 1, 0, 1, "R8 low twice");

        // R9/R10: rollover coinciding with a held clear
        do_reset();
        repeat (20) step(0, 0, 1, 1, "R10 set wins over clear");
        // R9/R10: rollover then hold without clear
        do_reset();
        repeat (24) step(0, 0, 0, 1, "R9 hold");
        step(0, 0, 1, 1, "R10 clear");
        step(0, 0, 0, 1, "R10 after clear");

        // R11: both strobes together
        step(1, 1, 0, 1, "R11 both");
        step(0, 1, 0, 1, "R11 low after both");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic h, l, c, e;
            h = ($urandom % 100) < 20;
            l = ($urandom % 100) < 20;
            c = ($urandom % 100) < 4;
            e = ($urandom % 100) < 92;
            step(h, l, c, e, "random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule